// File: doc/BRIEF.md
# Packed-to-Zoned Decimal Converter

This block turns one signed packed-decimal number into a string of zoned-decimal bytes. A producer presents the whole packed number at once, as a register of 4-bit digit nibbles with a sign nibble at the bottom, together with a digit count. The block takes it over a valid/ready handshake and then sends the zoned bytes downstream, one per cycle, most significant digit first. Each byte goes out over its own valid/ready handshake.

Every digit except the least significant one leaves as its ASCII code. The least significant byte carries the sign in its upper nibble, so no separate sign character is sent. Invalid digit or sign codes, and a count of zero, are rejected. The block raises a one-cycle error flag and sends nothing for that input. The block holds only one number at a time: the next input is taken only after the current final byte has been accepted.

Top module: `packedZoned`

## Requirements
- R1: After reset, outValid and errFlag are 0 and inReady is 1.
- R2: An input accepted with inValid and inReady both high, and with no coding error, makes outValid high on the next cycle. inReady stays low while any byte of that number is still pending.
- R3: Layout of inPacked: nibble 0 (bits 3:0) holds the sign, and nibble k holds the k-th digit counted from the least significant digit (k = 1..inCount). Bytes leave most significant digit first. Each byte except the final one is 0x30 plus the digit value.
- R4: The final byte has the digit in bits 3:0. Its bits 7:4 are 0xC for sign 0xC (positive), 0xD for sign 0xD (negative) and 0x3 for sign 0xF (unsigned).
- R5: Exactly inCount bytes are sent, for any inCount from 1 to 31. outLast is high on the final byte only, and outValid falls right after that byte is taken.
- R6: Nibbles above nibble inCount are ignored. This includes the zero pad nibble that a byte-aligned input with an even digit count carries. Their values never appear in the output and never cause an error.
- R7: If any of the inCount digit nibbles is above 9, errFlag is high for exactly the one cycle after acceptance, and no byte is sent.
- R8: A sign nibble other than 0xC, 0xD or 0xF is rejected in the same way as in R7.
- R9: An inCount of 0 is rejected in the same way as in R7.
- R10: While outValid is high and outReady is low, outValid, outData and outLast hold their values.
- R11: An input held valid during a stream is accepted only after the final byte has been taken, and it is then converted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Packed number offered |
| inReady | output | 1 | Converter idle and able to accept |
| inPacked | input | 128 | Packed digits, sign nibble at bits 3:0 |
| inCount | input | 5 | Number of digits, 1..31 |
| outValid | output | 1 | Zoned byte available |
| outReady | input | 1 | Downstream takes the byte |
| outData | output | 8 | Zoned byte |
| outLast | output | 1 | Byte carries the sign (final byte) |
| errFlag | output | 1 | One-cycle pulse on a rejected input |

## Verification
The hardest cases to reach from the ports are a stalled final byte and a second number already waiting at the input while the first number is still being sent. The bench keeps inValid high with a second number during the whole first stream and checks that inReady stays low. It then checks that the second stream follows straight after the final byte. Long 31-digit numbers are drained with a downstream that stalls on every third cycle. Garbage nibbles placed above the digit field confirm that only the counted nibbles are checked and sent.

// File: rtl/packedZonedPkg.sv
package packedZonedPkg;

  localparam logic [3:0] SIGN_POS  = 4'hC;
  localparam logic [3:0] SIGN_NEG  = 4'hD;
  localparam logic [3:0] SIGN_NONE = 4'hF;
  localparam logic [3:0] ZONE_DIGIT = 4'h3;

  typedef struct packed {
    logic load;
    logic step;
  } zdCtrl_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_EMIT = 1'b1} zdState_t;

  function automatic logic signValid(input logic [3:0] s);
    return (s == SIGN_POS) || (s == SIGN_NEG) || (s == SIGN_NONE);
  endfunction

  function automatic logic [3:0] zoneFor(input logic [3:0] s);
    case (s)
      SIGN_POS: return SIGN_POS;
      SIGN_NEG: return SIGN_NEG;
      default:  return ZONE_DIGIT;
    endcase
  endfunction

endpackage

// File: rtl/zonedDatapath.sv
module zonedDatapath
  import packedZonedPkg::*;
#(
  parameter int MAX_DIGITS = 31,
  localparam int CNT_W = $clog2(MAX_DIGITS + 1),
  localparam int PK_W  = (MAX_DIGITS + 1) * 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  zdCtrl_t          ctrl,
  input  logic [PK_W-1:0]  inPacked,
  input  logic [CNT_W-1:0] inCount,
  output logic             inBad,
  output logic             lastNow,
  output logic [7:0]       outData,
  input  logic             outValid
);

  logic [MAX_DIGITS-1:0] badVec;
  logic [PK_W-1:0]       pkReg;
  logic [CNT_W-1:0]      idx;
  logic [3:0]            zoneReg;
  logic [3:0]            curDigit;

  // per-digit range check, limited to the counted nibbles
  for (genvar k = 0; k < MAX_DIGITS; k++) begin : g_chk
    assign badVec[k] = (CNT_W'(k) < inCount) && (inPacked[(k+1)*4 +: 4] > 4'd9);
  end

  assign inBad = (|badVec) || !signValid(inPacked[3:0]) || (inCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pkReg   <= '0;
      idx     <= '0;
      zoneReg <= ZONE_DIGIT;
    end else if (ctrl.load) begin
      pkReg   <= inPacked;
      idx     <= inCount;
      zoneReg <= zoneFor(inPacked[3:0]);
    end else if (ctrl.step) begin
      idx <= idx - 1'b1;
    end
  end

  assign curDigit = pkReg[{idx, 2'b00} +: 4];
  assign lastNow  = (idx == CNT_W'(1));
  assign outData  = {lastNow ? zoneReg : ZONE_DIGIT, curDigit};

  // R3: non-final bytes are plain ASCII digits
  a_r3_ascii_digit: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !lastNow) |-> (outData[7:4] == 4'h3 && outData[3:0] <= 4'd9));

  // R4: final byte zone is one of the three legal codes
  a_r4_final_zone: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && lastNow) |-> (outData[7:4] == 4'hC || outData[7:4] == 4'hD || outData[7:4] == 4'h3));

endmodule

// File: rtl/zonedControl.sv
module zonedControl
  import packedZonedPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inBad,
  input  logic    lastNow,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output logic    errFlag,
  output zdCtrl_t ctrl
);

  zdState_t state;
  logic     accept;
  logic     take;

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_EMIT);
  assign accept   = inValid && inReady;
  assign take     = outValid && outReady;

  assign ctrl.load = accept && !inBad;
  assign ctrl.step = take && !lastNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      errFlag <= accept && inBad;
      case (state)
        ST_IDLE: if (accept && !inBad) state <= ST_EMIT;
        ST_EMIT: if (take && lastNow)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a good accept starts the stream on the next cycle
  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inBad) |=> outValid);

  // R11: no acceptance while a byte is pending
  a_r11_busy: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R7: a rejected input yields the error pulse and no output
  a_r7_reject: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inBad) |=> (errFlag && !outValid));

  // R5: stream ends right after the final byte is taken
  a_r5_end: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && lastNow) |=> !outValid);

endmodule

// File: rtl/packedZoned.sv
module packedZoned
  import packedZonedPkg::*;
#(
  parameter int MAX_DIGITS = 31,
  localparam int CNT_W = $clog2(MAX_DIGITS + 1),
  localparam int PK_W  = (MAX_DIGITS + 1) * 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PK_W-1:0]  inPacked,
  input  logic [CNT_W-1:0] inCount,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             outLast,
  output logic             errFlag
);

  zdCtrl_t ctrl;
  logic    inBad;
  logic    lastNow;

  zonedControl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBad(inBad),
    .lastNow(lastNow), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .errFlag(errFlag), .ctrl(ctrl)
  );

  zonedDatapath #(.MAX_DIGITS(MAX_DIGITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inPacked(inPacked),
    .inCount(inCount), .inBad(inBad), .lastNow(lastNow),
    .outData(outData), .outValid(outValid)
  );

  assign outLast = outValid && lastNow;

  // R10: a stalled byte holds steady
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

endmodule

// File: tb/packedZoned_test.sv
module packedZoned_test;

  typedef logic [3:0] digs_t [32];
  typedef logic [7:0] bytes_t [32];

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inPacked = '0;
  logic [4:0]   inCount = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [7:0]   outData;
  logic         outLast;
  logic         errFlag;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  packedZoned uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPacked(inPacked), .inCount(inCount), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast),
    .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // d[0] is the most significant digit; nibble n-i holds d[i]
  function automatic logic [127:0] mkPk(input int n, input digs_t d,
                                        input logic [3:0] sgn, input logic [3:0] fill);
    logic [127:0] p;
    for (int j = 0; j < 32; j++) p[j*4 +: 4] = fill;
    p[3:0] = sgn;
    for (int i = 0; i < n; i++) p[(n-i)*4 +: 4] = d[i];
    return p;
  endfunction

  function automatic bytes_t mkExp(input int n, input digs_t d, input logic [3:0] sgn);
    bytes_t e;
    logic [3:0] z;
    z = (sgn == 4'hC) ? 4'hC : (sgn == 4'hD) ? 4'hD : 4'h3;
    for (int i = 0; i < 32; i++) e[i] = 8'h00;
    for (int i = 0; i < n; i++) e[i] = (i == n-1) ? {z, d[i]} : {4'h3, d[i]};
    return e;
  endfunction

  // entered at a negedge; leaves at the negedge after the final handshake
  task automatic collect(input int n, input bytes_t e, input bit stall, input string req);
    int got = 0;
    int guard = 0;
    while (got < n && guard < 400) begin
      outReady = stall ? (guard % 3 != 0) : 1'b1;
      if (outValid && outReady) begin
        check(outData == e[got] && outLast == (got == n-1), req, "byte/last",
              {23'd0, outLast, outData}, {23'd0, (got == n-1), e[got]});
        got++;
      end
      guard++;
      @(negedge clk);
    end
    check(got == n, "R5", "byte count", got, n);
    check(!outValid && inReady, "R5", "idle after final byte", {outValid, inReady}, 2'b01);
    outReady = 1'b0;
  endtask

  task automatic runNum(input int n, input digs_t d, input logic [3:0] sgn,
                        input logic [3:0] fill, input bit stall, input string req);
    @(negedge clk);
    inPacked = mkPk(n, d, sgn, fill);
    inCount  = 5'(n);
    inValid  = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid && !errFlag, "R2", "stream start", {outValid, errFlag}, 2'b10);
    collect(n, mkExp(n, d, sgn), stall, req);
  endtask

  task automatic runBad(input logic [127:0] pk, input int n, input string req);
    @(negedge clk);
    inPacked = pk;
    inCount  = 5'(n);
    inValid  = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(errFlag && !outValid, req, "error pulse, no output", {errFlag, outValid}, 2'b10);
    @(negedge clk);
    check(!errFlag && !outValid && inReady, req, "error one cycle", {errFlag, outValid, inReady}, 3'b001);
  endtask

  task automatic testReset();
    check(inReady && !outValid && !errFlag, "R1", "reset state",
          {inReady, outValid, errFlag}, 3'b100);
  endtask

  task automatic testBackToBack();
    digs_t a, b;
    for (int i = 0; i < 32; i++) begin a[i] = 4'(i % 10); b[i] = 4'((9 - i) % 10); end
    @(negedge clk);
    inPacked = mkPk(6, a, 4'hC, 4'h0);
    inCount  = 5'd6;
    inValid  = 1'b1;
    @(negedge clk);
    inPacked = mkPk(3, b, 4'hD, 4'h0);
    inCount  = 5'd3;
    check(!inReady, "R11", "busy during stream", inReady, 0);
    collect(6, mkExp(6, a, 4'hC), 1'b1, "R11");
    @(negedge clk);
    inValid = 1'b0;
    check(outValid, "R11", "queued number started", outValid, 1);
    collect(3, mkExp(3, b, 4'hD), 1'b0, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    digs_t d;
    logic [127:0] p;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();

    // R3 R4: +53842 -> 35 33 38 34 C2
    d[0]=4'd5; d[1]=4'd3; d[2]=4'd8; d[3]=4'd4; d[4]=4'd2;
    runNum(5, d, 4'hC, 4'h0, 1'b0, "R3/R4");
    // R4 R6: -6071 -> 36 30 37 D1, zero pad then garbage pad
    d[0]=4'd6; d[1]=4'd0; d[2]=4'd7; d[3]=4'd1;
    runNum(4, d, 4'hD, 4'h0, 1'b0, "R4/R6");
    runNum(4, d, 4'hD, 4'hE, 1'b1, "R6");
    // R4: unsigned -> plain ASCII
    d[0]=4'd9; d[1]=4'd0; d[2]=4'd9;
    runNum(3, d, 4'hF, 4'h0, 1'b0, "R4");
    // R5: single digit
    d[0]=4'd7;
    runNum(1, d, 4'hD, 4'hB, 1'b0, "R5");
    // R5 R10: 31 digits with stalls
    for (int i = 0; i < 32; i++) d[i] = 4'((i * 7) % 10);
    runNum(31, d, 4'hC, 4'h0, 1'b1, "R5/R10");

    // R7: bad digit in the middle
    d[0]=4'd1; d[1]=4'hB; d[2]=4'd2; d[3]=4'd3;
    runBad(mkPk(4, d, 4'hC, 4'h0), 4, "R7");
    // R8: bad sign
    d[1]=4'd4;
    runBad(mkPk(4, d, 4'hA, 4'h0), 4, "R8");
    // R9: zero count
    runBad(mkPk(1, d, 4'hC, 4'h0), 0, "R9");
    // R6: bad nibbles only above the count still convert
    p = mkPk(2, d, 4'hC, 4'hF);
    check(1'b1, "R6", "pattern built", 0, 0);
    d[0]=4'd1; d[1]=4'd4;
    runNum(2, d, 4'hC, 4'hF, 1'b0, "R6");

    testBackToBack();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule